// File: doc/BRIEF.md
# Instrument Cross-Trigger Sequencer

This block starts a downstream test instrument, for example a bank of memory self-test engines, when something happens on other instruments. It does not wait for a direct command from the test access port. It watches the upstream instrument's Invoke, Done and Fail lines and a monitored data bus. When the programmed condition is met, it raises a single start level toward the target. That level stays high until the sequencer is disarmed.

Configuration enters through a small scan-style register. Bits move serially from the scan input toward the scan output while the shift strobe is high. They are copied into a live configuration register only on an update strobe. There are four start modes:
- **Finish:** start when the upstream unit finishes.
- **Count:** start a programmed number of cycles after the upstream unit is invoked.
- **Absolute:** start when a free-running cycle counter reaches a programmed value.
- **Event:** start when the monitored bus equals a programmed value.

An override field selects whether the target's start input comes from the sequencer or from a scanned static bit.

Top module: `xtrig_seq`

## Requirements
- R1: While reset is high and after its release, `target_invoke` and `scan_out` are 0 until configuration or triggers say otherwise.
- R2: With `scan_shift` high, each clock moves the shift side one place toward bit 0 and loads `scan_in` into bit 30; `scan_out` is bit 0 of the shift side. Shifted bits have no effect on behaviour until `scan_update` copies the whole shift side into the live configuration.
- R3: Configuration word layout, bit 0 first: [0] arm, [2:1] mode (00 finish, 01 count, 10 absolute, 11 event), [3] fail gate, [4] production-only gate, [5] override select, [6] override value, [22:7] 16-bit count/cycle value, [30:23] 8-bit match value.
- R4: In finish mode, when armed, a rising edge on `up_done` starts the target; `target_invoke` is high from the next clock edge.
- R5: In finish mode with the fail gate set, a done edge seen while `up_fail` is high does not start the target.
- R6: In finish mode with the production-only gate set, a done edge seen while `prod_sel` is low does not start the target.
- R7: In count mode with value N>0, a rising edge on `up_invoke` sampled at clock edge k starts the target at edge k+N.
- R8: In count mode with value 0, the target starts at the clock edge that samples the invoke edge.
- R9: In absolute mode, the target starts at the clock edge that sees a cycle counter equal to the value. The counter is 0 during reset and counts up by one per clock after release.
- R10: In event mode, the target starts at the first clock edge at which `mon_bus` equals the match value. Other bus values do nothing.
- R11: Once started, the start level stays high, even across updates that keep arm set. An update with arm clear drops it at that edge.
- R12: Triggers are edge-detected and ignored while disarmed. A Done already high when arming produces no start.
- R13: With override select set, `target_invoke` equals the override value whatever the sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial configuration data in |
| scan_shift | input | 1 | Shift strobe for the shift side |
| scan_update | input | 1 | Copies the shift side into the live configuration |
| scan_out | output | 1 | Serial configuration data out (bit 0 of shift side) |
| up_invoke | input | 1 | Upstream instrument start indication |
| up_done | input | 1 | Upstream instrument finish indication |
| up_fail | input | 1 | Upstream instrument failure indication |
| prod_sel | input | 1 | High when the production flow is selected |
| mon_bus | input | 8 | Monitored data bus of another instrument |
| target_invoke | output | 1 | Start level toward the target instrument |

## Verification
Finish mode is driven through a table that sets the two gate bits against the Fail and production levels. The table tells each gate's blocking case apart from the case where the gate is present but open.

Count mode is tried with a zero and a nonzero value. This separates the immediate start from the delayed start and pins the delay to the exact edge.

Absolute mode is checked against a bench-side cycle count. Event mode is checked with near-miss bus values before the exact match.

Held triggers, disarmed triggers, updates without arm changes, un-updated shifts and the override path each show whether `target_invoke` moves when it must not.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

    localparam int XT_CNT_W = 16;
    localparam int XT_BUS_W = 8;

    typedef enum logic [1:0] {
        XT_FINISH = 2'b00,
        XT_COUNT  = 2'b01,
        XT_ABS    = 2'b10,
        XT_EVENT  = 2'b11
    } xt_mode_e;

    // Packed MSB first: arm lands in bit 0, match in the top bits.
    typedef struct packed {
        logic [XT_BUS_W-1:0] match;
        logic [XT_CNT_W-1:0] value;
        logic                force_val;
        logic                force_sel;
        logic                prod_only;
        logic                fail_gate;
        xt_mode_e            mode;
        logic                arm;
    } xt_cfg_t;

    localparam int XT_CFG_W = $bits(xt_cfg_t);

    // Finish-mode qualification: each gate blocks only when enabled.
    function automatic logic finish_ok(input xt_cfg_t c, input logic fail, input logic prod);
        return (!c.fail_gate || !fail) && (!c.prod_only || prod);
    endfunction

endpackage

// File: rtl/xtrig_scan_reg.sv
module xtrig_scan_reg
    import xtrig_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scan_in,
    input  logic    scan_shift,
    input  logic    scan_update,
    output logic    scan_out,
    output logic    shadow_arm,
    output xt_cfg_t live_cfg
);

    logic [XT_CFG_W-1:0] shift_q;
    logic [XT_CFG_W-1:0] live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            live_q  <= '0;
        end else begin
            if (scan_shift) begin
                shift_q <= {scan_in, shift_q[XT_CFG_W-1:1]};
            end
            if (scan_update) begin
                live_q <= shift_q;
            end
        end
    end

    assign scan_out   = shift_q[0];
    assign shadow_arm = shift_q[0];
    assign live_cfg   = xt_cfg_t'(live_q);

endmodule

// File: rtl/xtrig_edge.sv
module xtrig_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q;
    end

endmodule

// File: rtl/xtrig_engine.sv
module xtrig_engine
    import xtrig_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  xt_cfg_t             cfg,
    input  logic                disarm,
    input  logic                done_rise,
    input  logic                inv_rise,
    input  logic                up_fail,
    input  logic                prod_sel,
    input  logic [XT_BUS_W-1:0] mon_bus,
    output logic                seq_inv
);

    localparam logic [XT_CNT_W-1:0] ZERO = '0;

    logic [XT_CNT_W-1:0] cyc_q;
    logic [XT_CNT_W-1:0] cnt_q;
    logic                pend_q;
    logic                fired_q;
    logic                cond;
    logic                fire;
    logic                load;

    always_comb begin
        unique case (cfg.mode)
            XT_FINISH: cond = done_rise && finish_ok(cfg, up_fail, prod_sel);
            XT_COUNT:  cond = (inv_rise && cfg.value == ZERO) || (pend_q && cnt_q == ZERO);
            XT_ABS:    cond = (cyc_q == cfg.value);
            XT_EVENT:  cond = (mon_bus == cfg.match);
            default:   cond = 1'b0;
        endcase
    end

    assign fire = cfg.arm && !fired_q && cond;
    assign load = cfg.arm && !fired_q && !pend_q && (cfg.mode == XT_COUNT)
                  && inv_rise && (cfg.value != ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || disarm) begin
            fired_q <= 1'b0;
            pend_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (fire) begin
                fired_q <= 1'b1;
                pend_q  <= 1'b0;
            end else if (load) begin
                pend_q <= 1'b1;
                cnt_q  <= cfg.value - 1'b1;
            end else if (pend_q && cnt_q != ZERO) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign seq_inv = fired_q;

endmodule

// File: rtl/xtrig_seq.sv
module xtrig_seq
    import xtrig_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_in,
    input  logic                scan_shift,
    input  logic                scan_update,
    output logic                scan_out,
    input  logic                up_invoke,
    input  logic                up_done,
    input  logic                up_fail,
    input  logic                prod_sel,
    input  logic [XT_BUS_W-1:0] mon_bus,
    output logic                target_invoke
);

    xt_cfg_t    live_cfg;
    logic       shadow_arm;
    logic       disarm;
    logic [1:0] rise;
    logic       seq_inv;

    xtrig_scan_reg u_scan (
        .clk        (clk),
        .rst        (rst),
        .scan_in    (scan_in),
        .scan_shift (scan_shift),
        .scan_update(scan_update),
        .scan_out   (scan_out),
        .shadow_arm (shadow_arm),
        .live_cfg   (live_cfg)
    );

    xtrig_edge #(.N(2)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl ({up_invoke, up_done}),
        .rise(rise)
    );

    assign disarm = scan_update && !shadow_arm;

    xtrig_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .cfg      (live_cfg),
        .disarm   (disarm),
        .done_rise(rise[0]),
        .inv_rise (rise[1]),
        .up_fail  (up_fail),
        .prod_sel (prod_sel),
        .mon_bus  (mon_bus),
        .seq_inv  (seq_inv)
    );

    // Source select for the target's start input.
    assign target_invoke = live_cfg.force_sel ? live_cfg.force_val : seq_inv;

endmodule

// File: rtl/xtrig_seq_chk.sv
module xtrig_seq_chk (
    input logic clk,
    input logic rst,
    input logic scan_shift,
    input logic scan_update,
    input logic scan_out,
    input logic shadow_arm,
    input logic live_arm,
    input logic seq_inv
);

    AST_HOLD_STARTED: assert property (@(posedge clk) disable iff (rst)
        (seq_inv && !(scan_update && !shadow_arm)) |=> seq_inv); // R11

    AST_DISARM_DROPS: assert property (@(posedge clk) disable iff (rst)
        (scan_update && !shadow_arm) |=> !seq_inv); // R11

    AST_NO_START_DISARMED: assert property (@(posedge clk) disable iff (rst)
        (!live_arm && !seq_inv) |=> !seq_inv); // R12

    AST_SCAN_OUT_STILL: assert property (@(posedge clk) disable iff (rst)
        !scan_shift |=> $stable(scan_out)); // R2

    AST_ARM_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !scan_update |=> $stable(live_arm)); // R2

endmodule

bind xtrig_seq xtrig_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scan_shift (scan_shift),
    .scan_update(scan_update),
    .scan_out   (scan_out),
    .shadow_arm (shadow_arm),
    .live_arm   (live_cfg.arm),
    .seq_inv    (seq_inv)
);

// File: tb/xtrig_seq_tb.sv
module xtrig_seq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_in = 1'b0, scan_shift = 1'b0, scan_update = 1'b0;
    logic       scan_out;
    logic       up_invoke = 1'b0, up_done = 1'b0, up_fail = 1'b0, prod_sel = 1'b0;
    logic [7:0] mon_bus = 8'h00;
    logic       target_invoke;

    int checks = 0;
    int errors = 0;
    int wd     = 0;
    logic [15:0] ncyc;

    always #10 clk = ~clk; // 50 MHz

    xtrig_seq u_dut (
        .clk(clk), .rst(rst), .scan_in(scan_in), .scan_shift(scan_shift),
        .scan_update(scan_update), .scan_out(scan_out), .up_invoke(up_invoke),
        .up_done(up_done), .up_fail(up_fail), .prod_sel(prod_sel),
        .mon_bus(mon_bus), .target_invoke(target_invoke)
    );

    // Bench-side cycle count for R9: 0 in reset, +1 per clock afterwards.
    always @(posedge clk) begin
        if (rst) ncyc <= 16'd0;
        else     ncyc <= ncyc + 16'd1;
    end

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // R3 layout: {match, value, force_val, force_sel, prod_only, fail_gate, mode, arm}
    function automatic logic [30:0] mk(input logic arm, input logic [1:0] mode,
                                       input logic fg, input logic po, input logic fs,
                                       input logic fv, input logic [15:0] val,
                                       input logic [7:0] match);
        return {match, val, fv, fs, po, fg, mode, arm};
    endfunction

    task automatic shift_only(input logic [30:0] w);
        for (int i = 0; i < 31; i++) begin
            @(negedge clk);
            scan_shift = 1'b1;
            scan_in    = w[i];
        end
        @(negedge clk);
        scan_shift = 1'b0;
        scan_in    = 1'b0;
    endtask

    task automatic load_cfg(input logic [30:0] w);
        shift_only(w);
        scan_update = 1'b1;
        @(negedge clk);
        scan_update = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        up_done = 1'b1;
        @(negedge clk);
        up_done = 1'b0;
    endtask

    // {fail_gate, prod_only, fail level, prod level, expected start}
    localparam logic [4:0] FIN_VEC [8] = '{
        5'b00001, 5'b10100, 5'b10001, 5'b00101,
        5'b01000, 5'b01011, 5'b11011, 5'b11110
    };

    logic [30:0] w;
    logic [15:0] tgt;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 invoke in reset", target_invoke, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 invoke after reset", target_invoke, 1'b0);
        chk("R1 scan_out after reset", scan_out, 1'b0);

        pulse_done();
        chk("R12 done while disarmed", target_invoke, 1'b0);

        // R4 R5 R6 finish-mode gating table
        for (int v = 0; v < 8; v++) begin
            up_fail  = FIN_VEC[v][2];
            prod_sel = FIN_VEC[v][1];
            load_cfg(mk(1'b1, 2'b00, FIN_VEC[v][4], FIN_VEC[v][3], 1'b0, 1'b0, 16'd0, 8'd0));
            chk("R4 no start before done", target_invoke, 1'b0);
            pulse_done();
            chk("R4/R5/R6 finish gate", target_invoke, FIN_VEC[v][0]);
            load_cfg('0);
            chk("R11 disarm clears", target_invoke, 1'b0);
        end
        up_fail  = 1'b0;
        prod_sel = 1'b0;

        // R2: shift without update has no effect; then shift-out order
        w = mk(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 16'hC3A5, 8'h96);
        shift_only(w);
        pulse_done();
        chk("R2 no effect before update", target_invoke, 1'b0);
        for (int i = 0; i < 31; i++) begin
            @(negedge clk);
            chk("R2 scan_out order", scan_out, w[i]);
            scan_shift = 1'b1;
        end
        @(negedge clk);
        scan_shift = 1'b0;

        // R11 hold across keep-armed update
        load_cfg(mk(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 8'd0));
        pulse_done();
        repeat (5) @(negedge clk);
        chk("R11 held", target_invoke, 1'b1);
        load_cfg(mk(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'd7, 8'd0));
        chk("R11 held across armed update", target_invoke, 1'b1);
        load_cfg('0);
        chk("R11 dropped on disarm", target_invoke, 1'b0);

        // R12 held done does not start after arming
        @(negedge clk);
        up_done = 1'b1;
        load_cfg(mk(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 8'd0));
        repeat (4) @(negedge clk);
        chk("R12 held done no start", target_invoke, 1'b0);
        up_done = 1'b0;
        pulse_done();
        chk("R12 fresh edge starts", target_invoke, 1'b1);
        load_cfg('0);

        // R7 count 5
        load_cfg(mk(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'd5, 8'd0));
        up_invoke = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk("R7 count delay", target_invoke, (k == 6));
        end
        up_invoke = 1'b0;
        load_cfg('0);

        // R8 count 0
        load_cfg(mk(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 8'd0));
        @(negedge clk);
        up_invoke = 1'b1;
        @(negedge clk);
        chk("R8 count zero", target_invoke, 1'b1);
        up_invoke = 1'b0;
        load_cfg('0);

        // R9 absolute
        @(negedge clk);
        tgt = ncyc + 16'd100;
        load_cfg(mk(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, tgt, 8'd0));
        while (ncyc != tgt) @(negedge clk);
        chk("R9 before absolute cycle", target_invoke, 1'b0);
        @(negedge clk);
        chk("R9 at absolute cycle", target_invoke, 1'b1);
        load_cfg('0);

        // R10 event
        mon_bus = 8'h5A;
        load_cfg(mk(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 8'hA5));
        repeat (3) @(negedge clk);
        chk("R10 other value", target_invoke, 1'b0);
        mon_bus = 8'hA4;
        repeat (2) @(negedge clk);
        chk("R10 near miss", target_invoke, 1'b0);
        mon_bus = 8'hA5;
        @(negedge clk);
        chk("R10 match starts", target_invoke, 1'b1);
        mon_bus = 8'h00;
        load_cfg('0);

        // R13 override path
        load_cfg(mk(1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 16'd0, 8'd0));
        chk("R13 forced high", target_invoke, 1'b1);
        load_cfg(mk(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 16'd0, 8'd0));
        pulse_done();
        chk("R13 forced low masks start", target_invoke, 1'b0);
        load_cfg(mk(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 8'd0));
        chk("R13 sequencer path restored", target_invoke, 1'b1);
        load_cfg('0);
        chk("R11 final disarm", target_invoke, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule